// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

The controller collects eight peripheral interrupt lines and presents a single request to a processor. Each line is sampled at its level and latched in a pending register. A line reaches the processor only when two conditions hold: its enable bit is not set in the disable mask, and no interrupt of equal or higher priority is still in service. When the processor raises its acknowledge line, the winning line leaves the pending register and enters the in-service register in that same cycle. At the same time an 8-bit vector is produced, equal to a programmed base plus the line number.

A four-address register port lets the host perform these operations:

- read the pending lines;
- read and write the disable mask;
- read and write the base vector;
- select the rotating-priority mode or the polled mode;
- issue end-of-interrupt commands.

In the default fixed order, line 0 ranks highest. In rotating mode, a line that has just been retired moves to the bottom of the order. In polled mode, the request output stays quiet and the host reads the best candidate from the register port.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `req_out` is 0 and `vec_out` is 0x00. Address 0 reads 0x00, address 1 (mask) reads 0xFF, address 2 (base) reads 0x08, and address 3 reads 0x00.
- R2: A high level on `irq_in[i]` at a clock edge sets pending bit i. The bit stays set after the line drops, until the line is acknowledged. Reading address 0 returns the pending bits, with bit i for line i.
- R3: In the mask at address 1, a 1 in bit i disables line i and a 0 enables it. A disabled line stays pending but never raises `req_out`.
- R4: In fixed mode, line 0 has the highest priority and line 7 the lowest. On the cycle in which `ack` rises while `req_out` is high, the winning line's pending bit clears and its in-service bit sets.
- R5: The vector is the base (address 2) plus the winning line number, modulo 256. It appears on `vec_out` one cycle after `ack` rises and holds until the next acknowledge.
- R6: While a line is in service, lines of the same or lower priority do not raise `req_out`.
- R7: A pending enabled line of higher priority than every in-service line raises `req_out`, so interrupts can nest.
- R8: Writing 0x20 to address 0 clears exactly one in-service bit, the highest-priority one. Any other value written there has no effect.
- R9: Writing bit 0 of address 3 selects rotating mode. In that mode, the line retired by an end-of-interrupt command becomes the lowest priority, and the line after it becomes the highest.
- R10: Writing bit 1 of address 3 selects polled mode, in which `req_out` stays 0. Reading address 3 returns bit 7 set when a candidate exists and bits 2:0 holding its line number. The read has no side effect.
- R11: An acknowledge and an end-of-interrupt command in the same cycle both take effect. The old highest in-service bit clears and the new winner becomes in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines, level sampled |
| ack | input | 1 | Processor acknowledge; the rising edge grants |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command/pending, 1 mask, 2 base, 3 mode/poll |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| req_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last granted line |

## Verification
An acknowledge and an end-of-interrupt command can land in the same cycle, and each of them changes the in-service register. The bench first puts line 5 in service and then makes line 2 pending. It then raises `ack` in the same cycle as a 0x20 write. The judgement rests on three observations:

- `vec_out` must show the vector for line 2.
- A following request on line 6 must stay blocked, which proves line 2 is in service.
- After a single further end-of-interrupt, line 6 must be presented, which proves line 5 was retired by the colliding command.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic valid;
    idx_t idx;
  } pick_t;

  localparam logic [DATA_W-1:0] EOI_CODE = 8'h20;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_MASK = 2'd1,
    A_BASE = 2'd2,
    A_MODE = 2'd3
  } reg_addr_e;

  // distance from the top of the order; smaller is more urgent
  function automatic idx_t rank_of(idx_t idx, idx_t start);
    return idx_t'(idx - start);
  endfunction

  // most urgent set bit, walking the order that begins at start
  function automatic pick_t pick_top(logic [LINES-1:0] v, idx_t start);
    pick_t p;
    p = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      idx_t pos;
      pos = idx_t'(start + idx_t'(k));
      if (v[pos]) begin
        p.valid = 1'b1;
        p.idx   = pos;
      end
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] vec_of(logic [DATA_W-1:0] base, idx_t idx);
    return base + DATA_W'(idx);
  endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic [LINES-1:0] take,
  output logic [LINES-1:0] pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending | irq_lines) & ~take;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines[g] && !take[g]) |=> pending[g]);
    // R4
    take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] |-> pending[g]);
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] in_svc,
  input  idx_t             start,
  output pick_t            present,
  output pick_t            isr_top
);
  pick_t cand;
  pick_t top;

  always_comb begin
    cand    = pick_top(pending & ~mask, start);
    top     = pick_top(in_svc, start);
    present = cand;
    if (top.valid && (rank_of(cand.idx, start) >= rank_of(top.idx, start)))
      present.valid = 1'b0;
  end

  assign isr_top = top;

  // R3
  masked_never_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present.valid |-> (!mask[present.idx] && pending[present.idx]));
  // R6
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (present.valid && isr_top.valid) |-> (present.idx != isr_top.idx));
endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  idx_t             grant_idx,
  input  logic             eoi,
  input  pick_t            eoi_pick,
  input  logic             rotate,
  output logic [LINES-1:0] in_svc,
  output idx_t             lowest
);
  logic [LINES-1:0] set_v;
  logic [LINES-1:0] clr_v;
  logic             retire;

  assign retire = eoi && eoi_pick.valid;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (grant)  set_v[grant_idx]    = 1'b1;
    if (retire) clr_v[eoi_pick.idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_svc <= '0;
      lowest <= '1;
    end else begin
      in_svc <= (in_svc & ~clr_v) | set_v;
      if (!rotate)     lowest <= '1;
      else if (retire) lowest <= eoi_pick.idx;
    end
  end

  // R4
  grant_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> in_svc[$past(grant_idx)]);
  // R8
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !grant) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
  // R11
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && grant) |=> ($countones(in_svc) == $countones($past(in_svc))));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter logic [7:0] BASE_RESET = 8'h08,
  parameter logic [7:0] MASK_RESET = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       ack,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       req_out,
  output logic [7:0] vec_out
);
  logic [LINES-1:0]  mask_q;
  logic [DATA_W-1:0] base_q;
  logic              rot_q;
  logic              poll_q;
  logic              ack_q;
  logic [DATA_W-1:0] vec_q;

  logic              ack_rise;
  logic              grant;
  logic              eoi_hit;
  logic [LINES-1:0]  take;
  logic [LINES-1:0]  pending;
  logic [LINES-1:0]  in_svc;
  pick_t             present;
  pick_t             isr_top;
  idx_t              lowest;
  idx_t              start;

  assign ack_rise = ack && !ack_q;
  assign grant    = ack_rise && present.valid && !poll_q;
  assign eoi_hit  = reg_wr && (reg_addr == A_CMD) && (reg_wdata == EOI_CODE);
  assign start    = rot_q ? idx_t'(lowest + idx_t'(1)) : '0;

  always_comb begin
    take = '0;
    if (grant) take[present.idx] = 1'b1;
  end

  pic_req_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_in),
    .take      (take),
    .pending   (pending)
  );

  pic_resolver u_resolve (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .mask    (mask_q),
    .in_svc  (in_svc),
    .start   (start),
    .present (present),
    .isr_top (isr_top)
  );

  pic_service u_service (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .grant_idx (present.idx),
    .eoi       (eoi_hit),
    .eoi_pick  (isr_top),
    .rotate    (rot_q),
    .in_svc    (in_svc),
    .lowest    (lowest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_RESET;
      base_q <= BASE_RESET;
      rot_q  <= 1'b0;
      poll_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      ack_q <= ack;
      if (grant) vec_q <= vec_of(base_q, present.idx);
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask_q <= reg_wdata;
          A_BASE:  base_q <= reg_wdata;
          A_MODE: begin
            rot_q  <= reg_wdata[0];
            poll_q <= reg_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = pending;
      A_MASK:  reg_rdata = mask_q;
      A_BASE:  reg_rdata = base_q;
      default: reg_rdata = {present.valid, 4'b0000, present.idx};
    endcase
  end

  assign req_out = present.valid && !poll_q;
  assign vec_out = vec_q;

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_q) |=> $stable(vec_q));
endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       ack;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       req_out;
  logic [7:0] vec_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pic_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_out(req_out), .vec_out(vec_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic eoi();
    wr(2'd0, 8'h20);
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq_in = lines;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic ack_cycle(input string req, input logic [7:0] exp);
    ack = 1'b1;
    @(negedge clk);
    chk(req, vec_out, exp);
    @(negedge clk);
    chk({req, " hold"}, vec_out, exp);
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 req_out", req_out, 0);
    chk("R1 vec_out", vec_out, 8'h00);
    rd(2'd0, d); chk("R1 pending", d, 8'h00);
    rd(2'd1, d); chk("R1 mask", d, 8'hFF);
    rd(2'd2, d); chk("R1 base", d, 8'h08);
    rd(2'd3, d); chk("R1 poll", d, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_latch_mask();
    logic [7:0] d;
    pulse(8'h10);
    rd(2'd0, d); chk("R2 latched", d, 8'h10);
    chk("R3 masked quiet", req_out, 0);
    @(negedge clk);
    rd(2'd0, d); chk("R2 stays after drop", d, 8'h10);
    @(negedge clk);
    wr(2'd1, 8'hEF);
    chk("R3 enabled line shown", req_out, 1);
    ack_cycle("R5 vector line4", 8'h0C);
    rd(2'd0, d); chk("R4 pending moved", d, 8'h00);
    @(negedge clk);
    eoi();
    wr(2'd1, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    pulse(8'hA4);
    chk("R4 request up", req_out, 1);
    ack_cycle("R4 line2 wins", 8'h0A);
    chk("R6 lower held", req_out, 0);
    pulse(8'h04);
    chk("R6 same held", req_out, 0);
    eoi();
    chk("R6 released", req_out, 1);
    ack_cycle("R4 line2 again", 8'h0A);
    eoi();
    ack_cycle("R4 line5", 8'h0D);
    eoi();
    ack_cycle("R4 line7", 8'h0F);
    eoi();
    chk("R4 idle", req_out, 0);
    rd(2'd0, d); chk("R4 none pending", d, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_nest();
    wr(2'd2, 8'hFC);
    pulse(8'h40);
    ack_cycle("R5 wrap line6", 8'h02);
    pulse(8'h02);
    chk("R7 nest request", req_out, 1);
    ack_cycle("R7 nested line1", 8'hFD);
    wr(2'd0, 8'h21);
    pulse(8'h08);
    chk("R8 other code ignored", req_out, 0);
    eoi();
    chk("R8 top retired", req_out, 1);
    ack_cycle("R8 line3", 8'hFF);
    eoi();
    chk("R8 idle", req_out, 0);
    pulse(8'h80);
    chk("R8 line6 still in service", req_out, 0);
    eoi();
    chk("R8 line6 retired", req_out, 1);
    ack_cycle("R5 wrap line7", 8'h03);
    eoi();
    eoi();
    chk("R8 over-ack quiet", req_out, 0);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_rotate();
    wr(2'd3, 8'h01);
    pulse(8'h11);
    ack_cycle("R9 line0 first", 8'h08);
    eoi();
    ack_cycle("R9 line4", 8'h0C);
    eoi();
    pulse(8'h41);
    ack_cycle("R9 line6 over line0", 8'h0E);
    eoi();
    ack_cycle("R9 line0 last", 8'h08);
    eoi();
    wr(2'd3, 8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    wr(2'd3, 8'h02);
    pulse(8'h28);
    chk("R10 no request", req_out, 0);
    rd(2'd3, d); chk("R10 poll read", d, 8'h83);
    rd(2'd3, d); chk("R10 poll repeat", d, 8'h83);
    rd(2'd0, d); chk("R10 pending intact", d, 8'h28);
    @(negedge clk);
    wr(2'd3, 8'h00);
    chk("R10 request after mode off", req_out, 1);
    ack_cycle("R10 line3", 8'h0B);
    eoi();
    ack_cycle("R10 line5", 8'h0D);
    eoi();
    wr(2'd3, 8'h02);
    rd(2'd3, d); chk("R10 poll empty", d, 8'h00);
    @(negedge clk);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_collide();
    pulse(8'h20);
    ack_cycle("R11 line5", 8'h0D);
    pulse(8'h04);
    chk("R11 nest request", req_out, 1);
    ack = 1'b1;
    reg_addr = 2'd0; reg_wdata = 8'h20; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 vector line2", vec_out, 8'h0A);
    ack = 1'b0;
    @(negedge clk);
    pulse(8'h40);
    chk("R11 line2 in service", req_out, 0);
    eoi();
    chk("R11 line5 retired", req_out, 1);
    ack_cycle("R11 line6", 8'h0E);
    eoi();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; ack = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_mask();
    t_prio();
    t_nest();
    t_rotate();
    t_poll();
    t_collide();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule